// File: doc/BRIEF.md
# Paged SPI Register Access Engine

This block is the master side of a register link to a sensor whose register map is split into pages of byte-wide registers. A client raises a one-cycle start with an operation (read, write or masked read-modify-write), a register address, a byte count, write data and a mask. The engine turns that request into a series of 16-bit SPI frames. Each frame carries a command byte and then a data byte. Chip select rises between frames, and each frame is followed by a stall time whose length depends on the frame type. When the request finishes, the engine reports done, error and the read value.

The engine keeps track of which page the sensor currently has selected. If a request falls in a different page, it first sends one frame that writes the new page number to the page-select register. The tracked page is committed only when an access completes cleanly. Writes are sent one byte per frame. Reads use a pipeline in which the reply to each command comes back during the next frame, so every read ends with a dummy frame. The bit shifter uses SPI mode 3: the clock idles high, data changes on the falling edge and is sampled on the rising edge.

Top module: `spi_page_engine`

## Requirements
- R1: Every frame is 16 bits, command byte first, most significant bit first. Outside a frame, sclk is high and cs_n is high. mosi changes only on falling sclk edges, and miso is sampled on rising edges.
- R2: A write command byte is bit 7 = 1 with the 7-bit in-page offset in bits 6:0, followed by the data byte. A read command byte is bit 7 = 0 with the offset in bits 6:0, followed by a zero byte.
- R3: The page is address / PAGE_SIZE and the offset is address % PAGE_SIZE. If the page differs from the tracked page, the access starts with the frame {1, PAGE_REG, page}. Otherwise no such frame is sent.
- R4: After reset with paging enabled, the tracked page is unknown, so the first access always begins with a page-select frame. With PAGING = 0, no page-select frame is ever sent.
- R5: The tracked page changes only when an access completes without error. A rejected request leaves it unchanged.
- R6: A write of 1, 2 or 4 bytes sends one frame per byte, at offsets off, off+1, … in that order. The data bytes go from least significant to most significant.
- R7: A 2-byte read sends a read of off and then a zero dummy frame. A 4-byte read sends a read of off+2, then a read of off, then a dummy frame. The reply frame to each command is the halfword {byte at n+1, byte at n}, and the halfword from off+2 fills rdata[31:16].
- R8: A request with an unsupported size (anything other than 1, 2 or 4 for writes, or 2 or 4 for reads and read-modify-write) or with op code 3 is rejected. done and err rise in the cycle after start, rdata reads 0, busy stays low and cs_n never falls.
- R9: A read-modify-write (op 2) performs the read of R7 and then writes (old & ~mask) | (wdata & mask) at the same size, with no page-select frame between the two phases. rdata returns the old value.
- R10: Between two frames of one access, cs_n stays high for exactly STALL + GAP_CYC + 2 clock cycles. STALL is RD_STALL after a read or dummy frame and WR_STALL after a page or write frame.
- R11: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse with busy low. A start while busy is ignored. err and rdata hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request strobe, taken when idle |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_addr | input | ADDR_W | Register address (page and offset) |
| req_size | input | 3 | Byte count |
| req_wdata | input | 32 | Write data, least significant byte at the lowest address |
| req_mask | input | 32 | Bits replaced by a read-modify-write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request rejected |
| rdata | output | 32 | Last read value |
| sclk | output | 1 | SPI clock, idles high |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the sensor |
| miso | input | 1 | SPI data from the sensor |

## Verification
The assertions assume that miso is stable around rising sclk edges. They also assume that req_size and req_op are valid in the cycle req_start is sampled, and that reset is held for at least one clock. The bench stimulus stays within these limits: a slave model changes miso only on falling sclk edges and while chip select is low, and requests are driven at falling clk edges and held for a full cycle. The tests also keep every multi-byte access inside one page, because offset arithmetic wraps within 7 bits and the bench's memory model does not wrap.

// File: rtl/spe_pkg.sv
package spe_pkg;

  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RMW = 2'd2;

  typedef enum logic [1:0] {PH_PAGE, PH_RD, PH_WR} spe_phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_STALL, ST_GAP} spe_state_e;

  function automatic logic [31:0] spe_merge(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [31:0] mask_v);
    return (old_v & ~mask_v) | (new_v & mask_v);
  endfunction

endpackage

// File: rtl/spe_shifter.sv
module spe_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] tx_word,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        active,
  output logic        done,
  output logic [15:0] rx_word
);
  localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [HC_W-1:0] hc_q;
  logic [4:0]      bit_q;
  logic [15:0]     tx_q, rx_q;
  logic            act_q, sclk_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_q   <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q <= 1'b1;
          tx_q  <= tx_word;
          hc_q  <= '0;
          bit_q <= '0;
        end
      end else if (hc_q == HC_W'(HALF_CYC - 1)) begin
        hc_q   <= '0;
        sclk_q <= ~sclk_q;
        if (sclk_q) begin
          // falling edge: present the next bit (the first is already out)
          if (bit_q != 5'd0) tx_q <= {tx_q[14:0], 1'b0};
        end else begin
          // rising edge: sample
          rx_q  <= {rx_q[14:0], miso};
          bit_q <= bit_q + 5'd1;
          if (bit_q == 5'd15) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[15];
  assign active  = act_q;
  assign done    = done_q;
  assign rx_word = rx_q;

  // R1: the clock rests high whenever no frame is shifting
  a_r1_sclk_rest_high: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> sclk_q);
  // R1: a frame always ends on a rising edge
  a_r1_end_high: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sclk_q && !act_q));
  // R1: mosi never moves while sclk is low
  a_r1_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    (act_q && !sclk_q && $past(act_q) && !$past(sclk_q)) |-> $stable(tx_q));

endmodule

// File: rtl/spe_seq.sv
module spe_seq
  import spe_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PAGE_SIZE = 128,
  parameter int PAGE_REG  = 0,
  parameter int GAP_CYC   = 3,
  parameter int WR_STALL  = 2,
  parameter int RD_STALL  = 5,
  parameter int PAGING    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       req_mask,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              cs_n,
  output logic              sh_start,
  output logic [15:0]       sh_word,
  input  logic              sh_done,
  input  logic [15:0]       sh_rx
);
  localparam int OFF_W  = $clog2(PAGE_SIZE);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int STMAX  = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
  localparam int CMAX0  = (GAP_CYC > STMAX) ? GAP_CYC : STMAX;
  localparam int CMAX   = (CMAX0 > 1) ? CMAX0 : 1;
  localparam int CNT_W  = $clog2(CMAX + 1);

  spe_state_e        st_q;
  spe_phase_e        ph_q;
  logic [2:0]        idx_q, size_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wbuf_q, mask_q, rbuf_q, rdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] cur_page_q;
  logic              cur_ok_q, busy_q, done_q, err_q, cs_q, start_q;

  logic [PAGE_W-1:0] req_page;
  logic              need_page, size_ok;
  logic [6:0]        off7;
  logic [2:0]        rd_last, wr_last;
  logic              ph_last, final_frame;
  logic [7:0]        wbyte;

  assign req_page  = req_addr[ADDR_W-1:OFF_W];
  assign need_page = (PAGING != 0) && (!cur_ok_q || (cur_page_q != req_page));

  always_comb begin
    case (req_op)
      OP_RD, OP_RMW: size_ok = (req_size == 3'd2) || (req_size == 3'd4);
      OP_WR:         size_ok = (req_size == 3'd1) || (req_size == 3'd2) ||
                               (req_size == 3'd4);
      default:       size_ok = 1'b0;
    endcase
  end

  assign off7    = 7'(addr_q[OFF_W-1:0]);
  assign rd_last = (size_q == 3'd4) ? 3'd2 : 3'd1;
  assign wr_last = size_q - 3'd1;

  always_comb begin
    case (ph_q)
      PH_PAGE: ph_last = 1'b1;
      PH_RD:   ph_last = (idx_q == rd_last);
      default: ph_last = (idx_q == wr_last);
    endcase
  end
  assign final_frame = ph_last &&
                       ((ph_q == PH_WR) || ((ph_q == PH_RD) && (op_q != OP_RMW)));

  always_comb begin
    case (idx_q[1:0])
      2'd0:    wbyte = wbuf_q[7:0];
      2'd1:    wbyte = wbuf_q[15:8];
      2'd2:    wbyte = wbuf_q[23:16];
      default: wbyte = wbuf_q[31:24];
    endcase
  end

  always_comb begin
    case (ph_q)
      PH_PAGE: sh_word = {1'b1, 7'(PAGE_REG), 8'(addr_q[ADDR_W-1:OFF_W])};
      PH_RD: begin
        if (idx_q == rd_last) sh_word = 16'h0000;
        else if ((size_q == 3'd4) && (idx_q == 3'd0))
          sh_word = {1'b0, off7 + 7'd2, 8'h00};
        else
          sh_word = {1'b0, off7, 8'h00};
      end
      default: sh_word = {1'b1, off7 + 7'(idx_q), wbyte};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_PAGE;
      idx_q      <= '0;
      size_q     <= '0;
      op_q       <= '0;
      addr_q     <= '0;
      wbuf_q     <= '0;
      mask_q     <= '0;
      rbuf_q     <= '0;
      rdata_q    <= '0;
      cnt_q      <= '0;
      cur_page_q <= '0;
      cur_ok_q   <= (PAGING == 0);
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      cs_q       <= 1'b1;
      start_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      start_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_start) begin
            if (!size_ok) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end else begin
              busy_q  <= 1'b1;
              err_q   <= 1'b0;
              op_q    <= req_op;
              size_q  <= req_size;
              addr_q  <= req_addr;
              wbuf_q  <= req_wdata;
              mask_q  <= req_mask;
              rbuf_q  <= '0;
              idx_q   <= '0;
              if (need_page)            ph_q <= PH_PAGE;
              else if (req_op == OP_WR) ph_q <= PH_WR;
              else                      ph_q <= PH_RD;
              st_q    <= ST_XFER;
              cs_q    <= 1'b0;
              start_q <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (sh_done) begin
            cs_q <= 1'b1;
            if ((ph_q == PH_RD) && (idx_q != 3'd0)) begin
              if ((size_q == 3'd4) && (idx_q == 3'd1)) rbuf_q[31:16] <= sh_rx;
              else                                     rbuf_q[15:0]  <= sh_rx;
            end
            cnt_q <= (ph_q == PH_RD) ? CNT_W'(RD_STALL) : CNT_W'(WR_STALL);
            st_q  <= ST_STALL;
          end
        end
        ST_STALL: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (final_frame) begin
            st_q       <= ST_IDLE;
            busy_q     <= 1'b0;
            done_q     <= 1'b1;
            rdata_q    <= rbuf_q;
            cur_page_q <= addr_q[ADDR_W-1:OFF_W];
            cur_ok_q   <= 1'b1;
          end else begin
            st_q  <= ST_GAP;
            cnt_q <= CNT_W'(GAP_CYC);
            case (ph_q)
              PH_PAGE: begin
                ph_q  <= (op_q == OP_WR) ? PH_WR : PH_RD;
                idx_q <= '0;
              end
              PH_RD: begin
                if (ph_last) begin
                  ph_q   <= PH_WR;
                  idx_q  <= '0;
                  wbuf_q <= spe_merge(rbuf_q, wbuf_q, mask_q);
                end else begin
                  idx_q <= idx_q + 3'd1;
                end
              end
              default: idx_q <= idx_q + 3'd1;
            endcase
          end
        end
        default: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            st_q    <= ST_XFER;
            cs_q    <= 1'b0;
            start_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rdata    = rdata_q;
  assign cs_n     = cs_q;
  assign sh_start = start_q;

  // R11: completion is a single-cycle pulse, never during busy
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R8: a rejected request touches no bus line and flags the error
  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && req_start && !size_ok) |=> (cs_q && !busy_q && err_q && done_q));
  // R5: the tracked page moves only on a clean completion
  a_r5_page_commit: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_page_q) |-> (done_q && !err_q));

endmodule

// File: rtl/spi_page_engine.sv
module spi_page_engine #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_SIZE = 128,
  parameter int PAGE_REG  = 0,
  parameter int HALF_CYC  = 2,
  parameter int GAP_CYC   = 3,
  parameter int WR_STALL  = 2,
  parameter int RD_STALL  = 5,
  parameter int PAGING    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       req_mask,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic        sh_start, sh_done, sh_active;
  logic [15:0] sh_word, sh_rx;

  spe_seq #(
    .ADDR_W(ADDR_W), .PAGE_SIZE(PAGE_SIZE), .PAGE_REG(PAGE_REG),
    .GAP_CYC(GAP_CYC), .WR_STALL(WR_STALL), .RD_STALL(RD_STALL),
    .PAGING(PAGING)
  ) i_seq (
    .clk(clk), .rst(rst),
    .req_start(req_start), .req_op(req_op), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_mask(req_mask),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .cs_n(cs_n), .sh_start(sh_start), .sh_word(sh_word),
    .sh_done(sh_done), .sh_rx(sh_rx)
  );

  spe_shifter #(.HALF_CYC(HALF_CYC)) i_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx_word(sh_word), .miso(miso),
    .sclk(sclk), .mosi(mosi), .active(sh_active), .done(sh_done),
    .rx_word(sh_rx)
  );

  // R1: no clocking while the sensor is deselected
  a_r1_cs_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!sh_active && sclk));
  // R11: the bus is only ever selected inside an access
  a_r11_cs_in_busy: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

endmodule

// File: tb/test_spi_page_engine.sv
module test_spi_page_engine;
  localparam int AW = 9, PS = 128, PREG = 0, HALF = 2, GAP = 3, WRS = 2, RDS = 5;
  localparam int OPR = 0, OPW = 1, OPM = 2;

  logic clk = 1'b0, rst = 1'b1, req_start = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_size = '0;
  logic [31:0] req_wdata = '0, req_mask = '0;
  logic busy, done, err, sclk, cs_n, mosi, miso;
  logic [31:0] rdata;

  spi_page_engine #(.ADDR_W(AW), .PAGE_SIZE(PS), .PAGE_REG(PREG), .HALF_CYC(HALF),
    .GAP_CYC(GAP), .WR_STALL(WRS), .RD_STALL(RDS), .PAGING(1)) i_spi_page_engine (
    .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_mask(req_mask), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [7:0] smem [512];
  logic [7:0] rmem [512];
  int spage = 0, ref_page = 0;
  bit ref_ok = 0;
  logic [15:0] got [$];
  logic [15:0] expf [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // slave model: mode 3, reply to a command comes in the next frame
  logic [15:0] s_in = '0, s_out = '0, s_pend = '0;
  int s_bits = 0;
  assign miso = s_out[15];

  task automatic slave_frame(input logic [15:0] f);
    int a;
    got.push_back(f);
    a = int'(f[14:8]);
    if (f[15]) begin
      if (a == PREG) spage = int'(f[7:0]);
      else smem[spage*PS + a] = f[7:0];
      s_pend = 16'h0;
    end else begin
      s_pend = {smem[spage*PS + a + 1], smem[spage*PS + a]};
    end
  endtask

  always @(negedge cs_n) begin s_out = s_pend; s_bits = 0; end
  always @(posedge sclk) if (!cs_n) begin
    s_in = {s_in[14:0], mosi};
    s_bits++;
    if (s_bits == 16) slave_frame(s_in);
  end
  always @(negedge sclk) if (!cs_n && s_bits > 0) s_out = {s_out[14:0], 1'b0};

  // per-clock observation: idle levels and inter-frame spacing
  logic prev_cs = 1'b1;
  int hi = 0;
  bit armed = 0;
  always @(negedge clk) if (!rst) begin
    if (cs_n && !sclk) chk(0, "R1", "sclk low while deselected", {31'b0, sclk}, 1);
    if (!busy && !cs_n) chk(0, "R11", "cs_n low while idle", {31'b0, cs_n}, 1);
    if (prev_cs && !cs_n) begin
      if (armed && got.size() > 0)
        chk(hi == ((got[$][15] ? WRS : RDS) + GAP + 2), "R10", "cs_n high cycles",
            hi, (got[$][15] ? WRS : RDS) + GAP + 2);
      armed = 1;
    end
    if (cs_n) hi++; else hi = 0;
    if (!busy && cs_n) armed = 0;
    prev_cs = cs_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] hw(input int pg, input int o);
    return {rmem[pg*PS + o + 1], rmem[pg*PS + o]};
  endfunction

  task automatic do_op(input int op, input int addr, input int size,
                       input logic [31:0] wd, input logic [31:0] mk,
                       input string req, input bit poke);
    int pg, off, t;
    bit bad;
    logic [31:0] expv, wv;
    pg = addr / PS; off = addr % PS; expv = '0;
    if (op == OPW) bad = !(size == 1 || size == 2 || size == 4);
    else if (op == OPR || op == OPM) bad = !(size == 2 || size == 4);
    else bad = 1;
    expf.delete(); got.delete();
    if (!bad) begin
      if (!ref_ok || pg != ref_page) expf.push_back({1'b1, 7'(PREG), 8'(pg)});
      if (op != OPW) begin
        if (size == 4) begin
          expf.push_back({1'b0, 7'(off + 2), 8'h00});
          expf.push_back({1'b0, 7'(off), 8'h00});
          expv = {hw(pg, off + 2), hw(pg, off)};
        end else begin
          expf.push_back({1'b0, 7'(off), 8'h00});
          expv = {16'h0, hw(pg, off)};
        end
        expf.push_back(16'h0000);
      end
      wv = (op == OPM) ? ((expv & ~mk) | (wd & mk)) : wd;
      if (op != OPR)
        for (int k = 0; k < size; k++) begin
          expf.push_back({1'b1, 7'(off + k), wv[8*k +: 8]});
          rmem[pg*PS + off + k] = wv[8*k +: 8];
        end
      ref_page = pg; ref_ok = 1;
    end
    @(negedge clk);
    req_op = 2'(op); req_addr = AW'(addr); req_size = 3'(size);
    req_wdata = wd; req_mask = mk; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy == !bad, "R11", {req, " busy after start"}, {31'b0, busy}, {31'b0, !bad});
    if (poke) begin
      @(negedge clk);
      req_op = 2'(OPW); req_addr = 9'h0F3; req_size = 3'd1; req_wdata = 32'hFF; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, req, "done seen", {31'b0, done}, 1);
    chk(err == bad, bad ? "R8" : req, "err flag", {31'b0, err}, {31'b0, bad});
    if (op != OPW) chk(rdata == expv, req, "read value", rdata, expv);
    repeat (3) @(negedge clk);
    chk(!done, "R11", "done single pulse", {31'b0, done}, 0);
    if (op != OPW) chk(rdata == expv, "R11", "rdata held", rdata, expv);
    chk(got.size() == expf.size(), req, "frame count", got.size(), expf.size());
    for (int i = 0; i < expf.size() && i < got.size(); i++)
      chk(got[i] == expf[i], req, $sformatf("frame %0d", i), {16'h0, got[i]}, {16'h0, expf[i]});
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      smem[i] = 8'(i * 7 + 3);
      rmem[i] = 8'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && cs_n && sclk && rdata == 0, "R1",
        "reset levels", {27'b0, busy, done, err, cs_n, sclk}, 5'b00011);
    do_op(OPW, 9'h090, 2, 32'h0000_1234, 0, "R4", 0);           // first access selects page
    do_op(OPR, 9'h090, 2, 0, 0, "R7", 0);                       // same page, no select (R3)
    do_op(OPW, 9'h0A0, 4, 32'hDEAD_BEEF, 0, "R6", 0);
    do_op(OPR, 9'h0A0, 4, 0, 0, "R7", 0);
    do_op(OPW, 9'h105, 1, 32'h0000_005A, 0, "R3", 0);           // page change, R2 write byte
    do_op(OPR, 9'h1C0, 4, 0, 0, "R2", 0);                       // read command bytes, page 3
    do_op(OPM, 9'h090, 2, 32'h0000_ABCD, 32'h0000_0F0F, "R9", 1); // start while busy ignored (R11)
    do_op(OPM, 9'h130, 4, 32'h1122_3344, 32'hFF00_FF00, "R9", 0);
    do_op(OPR, 9'h020, 1, 0, 0, "R8", 0);                       // bad size on page 0
    do_op(OPR, 9'h130, 2, 0, 0, "R5", 0);                       // page 2 kept: no select frame
    do_op(OPW, 9'h1C0, 3, 32'h77, 0, "R8", 0);
    do_op(3,   9'h1C0, 2, 0, 0, "R8", 0);
    do_op(OPW, 9'h020, 2, 32'h0000_C0DE, 0, "R6", 0);
    do_op(OPR, 9'h190, 2, 0, 0, "R3", 0);
    do_op(OPR, 9'h020, 2, 0, 0, "R7", 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule